// File: doc/BRIEF.md
# Coherent Line-State Controller for a Two-Way Data Cache

This block holds the coherence state, tag and replacement bit of every line in a small two-way set-associative data cache. For each processor access and each external snoop it decides what must happen on the system bus. The possible bus actions are a burst refill of a line, a single write-through beat, an uncached single read, or a burst write-back of a dirty line. Data storage is not part of the block. It tracks which lines are present and in which of four coherence states: Modified, Exclusive, Shared or Invalid.

The processor raises a request and holds its inputs until the block pulses a completion with a hit flag. A snoop works the same way and completes with a hit flag and a hit-on-dirty flag. When both are pending in the idle state, the snoop is served first. Each bus request stays asserted until the memory side acknowledges enough beats. A line is 32 bytes, so a refill or a write-back takes four 64-bit beats. A write-through or an uncached read takes one beat.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus request is raised, no completion is pulsed, and the first read of any address misses.
- R2: A read miss raises the refill request at the line-aligned address (low five bits zero) for four acknowledged beats. The refilled line becomes Exclusive if the write-back mode input was 1, or Shared if it was 0. The processor completion then pulses with hit 0 in the cycle after the fourth beat.
- R3: A read that hits a valid line completes in the cycle after the request is seen, with hit 1 and no bus request.
- R4: A write that hits an Exclusive or Modified line completes with hit 1 and no bus request. The line becomes Modified.
- R5: A write that hits a Shared line issues one write-through beat at the full processor address, completes with hit 1, and leaves the line Shared.
- R6: A write that misses issues one write-through beat at the full address and completes with hit 0. It allocates no line, so a following read of the same line still misses.
- R7: A read snoop that hits a Modified line writes the line back in four beats at its line address. It then completes with snoop-hit 1 and hit-modified 1 and leaves the line Shared.
- R8: A write snoop that hits any valid line leaves it Invalid, after a four-beat write-back if it was Modified.
- R9: A read snoop that hits an Exclusive or Shared line completes with snoop-hit 1, hit-modified 0 and no bus cycle, and leaves the line Shared. A snoop miss completes with both flags 0.
- R10: Each set has one replacement bit naming the victim way. Any processor hit or refill of a way points the bit at the other way. A Modified victim is written back in four beats at its own line address before the refill starts.
- R11: While cache-disable is 1, reads raise one uncached read beat and writes one write-through beat, both at the full address. Completion reports hit 0 and no line changes state.
- R12: At most one of the four bus requests is active at a time, and the bus address holds steady while a request waits for its acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access pending, held until cpu_done |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | AW | Processor byte address |
| wb_mode | input | 1 | 1 selects write-back for the line refilled by this access |
| cache_dis | input | 1 | 1 sends every processor access to the bus uncached |
| cpu_done | output | 1 | One-cycle completion pulse for the processor access |
| cpu_hit | output | 1 | Hit flag, valid with cpu_done |
| snp_req | input | 1 | Snoop pending, held until snp_done |
| snp_we | input | 1 | 1 if the snoop comes from an external write |
| snp_addr | input | AW | Snooped byte address |
| snp_done | output | 1 | One-cycle snoop completion pulse |
| snp_hit | output | 1 | Snooped line was valid, valid with snp_done |
| snp_hitm | output | 1 | Snooped line was Modified, valid with snp_done |
| fill_req | output | 1 | Burst refill request |
| wb_req | output | 1 | Burst write-back request |
| wt_req | output | 1 | Single-beat write-through request |
| rd_req | output | 1 | Single-beat uncached read request |
| bus_addr | output | AW | Address of the active bus request |
| bus_ack | input | 1 | Memory accepted one beat of the active request |

## Verification
The checker watches the bus handshake on every cycle. It requires exclusive bus requests and a steady address until acknowledgement. It also requires that a completion pulse follows the end of every refill and write-through, that a victim write-back leads straight into a refill, that hit-modified only follows a write-back, and that no hit is reported with the cache disabled. Only the bench scenarios can show the state transitions themselves, because they become visible later through a different access: the Modified state after a write, a Shared line after a read snoop, a missing allocation after a write miss, and the replacement bit's choice of victim. The bench compares each access against its own four-state model of every set.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    typedef enum logic [2:0] {
        FS_IDLE = 3'd0,
        FS_VWB  = 3'd1,   // victim write-back before a refill
        FS_FILL = 3'd2,
        FS_WT   = 3'd3,
        FS_RD1  = 3'd4,   // uncached single read
        FS_SWB  = 3'd5    // snoop-triggered write-back
    } fsm_t;

endpackage

// File: rtl/mesi_tag_match.sv
module mesi_tag_match
    import mesi_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int TAG_W = 20,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0][1:0]       way_st,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output mesi_t                      hit_st
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = (way_st[w] != ST_I) && (way_tag[w] == look_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        hit_st  = ST_I;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way = WAY_W'(w);
                hit_st  = mesi_t'(way_st[w]);
            end
        end
    end

endmodule

// File: rtl/mesi_policy.sv
module mesi_policy
    import mesi_pkg::*;
(
    input  mesi_t cur,
    input  logic  snoop,
    input  logic  we,
    output mesi_t nxt,
    output logic  need_wt,
    output logic  need_wb
);

    always_comb begin
        nxt     = cur;
        need_wt = 1'b0;
        need_wb = 1'b0;
        if (snoop) begin
            need_wb = (cur == ST_M);
            if (cur != ST_I) begin
                nxt = we ? ST_I : ST_S;
            end
        end else if (we) begin
            case (cur)
                ST_M:    nxt = ST_M;
                ST_E:    nxt = ST_M;
                default: need_wt = 1'b1;   // Shared hit or miss
            endcase
        end
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int BUS_W      = 64,
    parameter int SETS       = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic          wb_mode,
    input  logic          cache_dis,
    output logic          cpu_done,
    output logic          cpu_hit,
    input  logic          snp_req,
    input  logic          snp_we,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_done,
    output logic          snp_hit,
    output logic          snp_hitm,
    output logic          fill_req,
    output logic          wb_req,
    output logic          wt_req,
    output logic          rd_req,
    output logic [AW-1:0] bus_addr,
    input  logic          bus_ack
);

    localparam int WAYS   = 2;   // one replacement bit per set
    localparam int WAY_W  = 1;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = AW - OFF_W - IDX_W;
    localparam int BEATS  = (LINE_BYTES * 8) / BUS_W;
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    typedef struct packed {
        fsm_t                                  fsm;
        logic [BEAT_W-1:0]                     beat;
        logic [AW-1:0]                         addr;
        logic [IDX_W-1:0]                      idx;
        logic [TAG_W-1:0]                      tag;
        logic [WAY_W-1:0]                      way;
        logic                                  mode;
        logic                                  pend_hit;
        mesi_t                                 pend_st;
        logic                                  cpu_done;
        logic                                  cpu_hit;
        logic                                  snp_done;
        logic                                  snp_hit;
        logic                                  snp_hitm;
        logic [WAYS-1:0][SETS-1:0][1:0]        st;
        logic [WAYS-1:0][SETS-1:0][TAG_W-1:0]  tags;
        logic [SETS-1:0]                       lru;
    } regs_t;

    regs_t r_d, r_q;

    function automatic logic [AW-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                input logic [IDX_W-1:0] i);
        return {t, i, {OFF_W{1'b0}}};
    endfunction

    // lookup on the request that the idle state will serve
    logic [AW-1:0]                   look_addr;
    logic [IDX_W-1:0]                lidx;
    logic [TAG_W-1:0]                ltag;
    logic [WAYS-1:0][TAG_W-1:0]      set_tag;
    logic [WAYS-1:0][1:0]            set_st;
    logic                            hit;
    logic [WAY_W-1:0]                hit_way;
    mesi_t                           hit_st;
    logic [WAY_W-1:0]                victim;
    logic                            last_beat;
    mesi_t                           cpu_nxt, snp_nxt;
    logic                            cpu_wt, cpu_wb_unused, snp_wt_unused, snp_wb;

    assign look_addr = snp_req ? snp_addr : cpu_addr;
    assign lidx      = look_addr[OFF_W +: IDX_W];
    assign ltag      = look_addr[AW-1 -: TAG_W];
    assign victim    = r_q.lru[lidx];
    assign last_beat = (r_q.beat == BEAT_W'(BEATS - 1));

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_tag[w] = r_q.tags[w][lidx];
            set_st[w]  = r_q.st[w][lidx];
        end
    end

    mesi_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .way_tag (set_tag),
        .way_st  (set_st),
        .look_tag(ltag),
        .hit     (hit),
        .hit_way (hit_way),
        .hit_st  (hit_st)
    );

    mesi_policy u_pol_cpu (
        .cur(hit_st), .snoop(1'b0), .we(cpu_we),
        .nxt(cpu_nxt), .need_wt(cpu_wt), .need_wb(cpu_wb_unused)
    );

    mesi_policy u_pol_snp (
        .cur(hit_st), .snoop(1'b1), .we(snp_we),
        .nxt(snp_nxt), .need_wt(snp_wt_unused), .need_wb(snp_wb)
    );

    always_comb begin
        r_d          = r_q;
        r_d.cpu_done = 1'b0;
        r_d.cpu_hit  = 1'b0;
        r_d.snp_done = 1'b0;
        r_d.snp_hit  = 1'b0;
        r_d.snp_hitm = 1'b0;

        case (r_q.fsm)
            FS_IDLE: begin
                r_d.beat = '0;
                r_d.idx  = lidx;
                r_d.tag  = ltag;
                if (snp_req) begin
                    if (hit && snp_wb) begin
                        r_d.fsm     = FS_SWB;
                        r_d.addr    = line_addr(ltag, lidx);
                        r_d.way     = hit_way;
                        r_d.pend_st = snp_nxt;
                    end else begin
                        r_d.st[hit_way][lidx] = hit ? snp_nxt : mesi_t'(set_st[hit_way]);
                        r_d.snp_done = 1'b1;
                        r_d.snp_hit  = hit;
                    end
                end else if (cpu_req) begin
                    if (cache_dis) begin
                        r_d.fsm      = cpu_we ? FS_WT : FS_RD1;
                        r_d.addr     = look_addr;
                        r_d.pend_hit = 1'b0;
                    end else if (hit) begin
                        r_d.lru[lidx]         = ~hit_way;
                        r_d.st[hit_way][lidx] = cpu_nxt;
                        if (cpu_wt) begin
                            r_d.fsm      = FS_WT;
                            r_d.addr     = look_addr;
                            r_d.pend_hit = 1'b1;
                        end else begin
                            r_d.cpu_done = 1'b1;
                            r_d.cpu_hit  = 1'b1;
                        end
                    end else if (cpu_we) begin
                        r_d.fsm      = FS_WT;
                        r_d.addr     = look_addr;
                        r_d.pend_hit = 1'b0;
                    end else begin
                        r_d.way  = victim;
                        r_d.mode = wb_mode;
                        if (set_st[victim] == ST_M) begin
                            r_d.fsm  = FS_VWB;
                            r_d.addr = line_addr(set_tag[victim], lidx);
                        end else begin
                            r_d.fsm  = FS_FILL;
                            r_d.addr = line_addr(ltag, lidx);
                        end
                    end
                end
            end

            FS_VWB: if (bus_ack) begin
                r_d.beat = r_q.beat + 1'b1;
                if (last_beat) begin
                    r_d.st[r_q.way][r_q.idx] = ST_I;
                    r_d.fsm  = FS_FILL;
                    r_d.beat = '0;
                    r_d.addr = line_addr(r_q.tag, r_q.idx);
                end
            end

            FS_FILL: if (bus_ack) begin
                r_d.beat = r_q.beat + 1'b1;
                if (last_beat) begin
                    r_d.st[r_q.way][r_q.idx]   = r_q.mode ? ST_E : ST_S;
                    r_d.tags[r_q.way][r_q.idx] = r_q.tag;
                    r_d.lru[r_q.idx]           = ~r_q.way;
                    r_d.fsm      = FS_IDLE;
                    r_d.cpu_done = 1'b1;
                end
            end

            FS_WT: if (bus_ack) begin
                r_d.fsm      = FS_IDLE;
                r_d.cpu_done = 1'b1;
                r_d.cpu_hit  = r_q.pend_hit;
            end

            FS_RD1: if (bus_ack) begin
                r_d.fsm      = FS_IDLE;
                r_d.cpu_done = 1'b1;
            end

            FS_SWB: if (bus_ack) begin
                r_d.beat = r_q.beat + 1'b1;
                if (last_beat) begin
                    r_d.st[r_q.way][r_q.idx] = r_q.pend_st;
                    r_d.fsm      = FS_IDLE;
                    r_d.snp_done = 1'b1;
                    r_d.snp_hit  = 1'b1;
                    r_d.snp_hitm = 1'b1;
                end
            end

            default: r_d.fsm = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_done = r_q.cpu_done;
    assign cpu_hit  = r_q.cpu_hit;
    assign snp_done = r_q.snp_done;
    assign snp_hit  = r_q.snp_hit;
    assign snp_hitm = r_q.snp_hitm;
    assign fill_req = (r_q.fsm == FS_FILL);
    assign wb_req   = (r_q.fsm == FS_VWB) || (r_q.fsm == FS_SWB);
    assign wt_req   = (r_q.fsm == FS_WT);
    assign rd_req   = (r_q.fsm == FS_RD1);
    assign bus_addr = r_q.addr;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cache_dis,
    input logic          cpu_done,
    input logic          cpu_hit,
    input logic          snp_done,
    input logic          snp_hit,
    input logic          snp_hitm,
    input logic          fill_req,
    input logic          wb_req,
    input logic          wt_req,
    input logic          rd_req,
    input logic          bus_ack,
    input logic [AW-1:0] bus_addr
);

    logic busy;
    assign busy = fill_req | wb_req | wt_req | rd_req;

    // R12
    one_bus_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fill_req, wb_req, wt_req, rd_req}) <= 1);

    // R12
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(bus_ack)) |-> $stable(bus_addr));

    // R2
    fill_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fill_req) |-> (cpu_done && !cpu_hit));

    // R5
    wt_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wt_req) |-> cpu_done);

    // R7
    hitm_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hitm |-> (snp_done && snp_hit && $past(wb_req)));

    // R10
    victim_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wb_req) && !snp_done) |-> fill_req);

    // R11
    disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cache_dis) |-> !cpu_hit);

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cache_dis(cache_dis),
    .cpu_done (cpu_done),
    .cpu_hit  (cpu_hit),
    .snp_done (snp_done),
    .snp_hit  (snp_hit),
    .snp_hitm (snp_hitm),
    .fill_req (fill_req),
    .wb_req   (wb_req),
    .wt_req   (wt_req),
    .rd_req   (rd_req),
    .bus_ack  (bus_ack),
    .bus_addr (bus_addr)
);

// File: tb/mesi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, wb_mode = 1'b1, cache_dis = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        snp_req = 1'b0, snp_we = 1'b0;
    logic [31:0] snp_addr = '0;
    logic        bus_ack = 1'b0;
    logic        cpu_done, cpu_hit, snp_done, snp_hit, snp_hitm;
    logic        fill_req, wb_req, wt_req, rd_req;
    logic [31:0] bus_addr;

    int n_cmp = 0, n_bad = 0;
    int n_fill, n_wb, n_wt, n_rd;
    logic [31:0] a_fill, a_wb, a_wt, a_rd;

    // bench model of every set
    logic [1:0]  m_st  [2][128];
    logic [19:0] m_tag [2][128];
    logic        m_lru [128];

    always #10 clk = ~clk;

    mesi_line_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .wb_mode(wb_mode), .cache_dis(cache_dis),
        .cpu_done(cpu_done), .cpu_hit(cpu_hit),
        .snp_req(snp_req), .snp_we(snp_we), .snp_addr(snp_addr),
        .snp_done(snp_done), .snp_hit(snp_hit), .snp_hitm(snp_hitm),
        .fill_req(fill_req), .wb_req(wb_req), .wt_req(wt_req), .rd_req(rd_req),
        .bus_addr(bus_addr), .bus_ack(bus_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int t, input int s, input int o);
        return {t[19:0], s[6:0], o[4:0]};
    endfunction

    function automatic logic [31:0] line_of(input logic [31:0] a);
        return {a[31:5], 5'b0};
    endfunction

    // memory responder: acks beats with random gaps and logs them
    initial begin
        forever begin
            @(negedge clk);
            if ((fill_req | wb_req | wt_req | rd_req) && ($urandom % 3 != 0)) begin
                bus_ack = 1'b1;
                if (fill_req) begin if (n_fill == 0) a_fill = bus_addr; n_fill++; end
                if (wb_req)   begin if (n_wb == 0)   a_wb   = bus_addr; n_wb++;   end
                if (wt_req)   begin if (n_wt == 0)   a_wt   = bus_addr; n_wt++;   end
                if (rd_req)   begin if (n_rd == 0)   a_rd   = bus_addr; n_rd++;   end
            end else begin
                bus_ack = 1'b0;
            end
        end
    end

    task automatic clear_log();
        n_fill = 0; n_wb = 0; n_wt = 0; n_rd = 0;
        a_fill = '0; a_wb = '0; a_wt = '0; a_rd = '0;
    endtask

    task automatic cpu_op(input bit we, input logic [31:0] a, input bit mode, input bit dis);
        logic [19:0] t;
        logic [6:0]  s;
        int          hw, ef, ewb, ewt, erd, k;
        bit          e_hit, a_hit;
        logic [31:0] ewba;
        logic [16:0] es, as_;
        string       rq;
        t = a[31:12]; s = a[11:5];
        hw = -1; ef = 0; ewb = 0; ewt = 0; erd = 0; e_hit = 0; ewba = '0;
        for (int w = 0; w < 2; w++)
            if (m_st[w][s] != 2'd0 && m_tag[w][s] == t) hw = w;
        if (dis) begin
            rq = "R11";
            if (we) ewt = 1; else erd = 1;
        end else if (hw >= 0) begin
            e_hit = 1;
            m_lru[s] = (hw == 0);
            if (!we) rq = "R3";
            else if (m_st[hw][s] == 2'd1) begin rq = "R5"; ewt = 1; end
            else begin rq = "R4"; m_st[hw][s] = 2'd3; end
        end else if (we) begin
            rq = "R6"; ewt = 1;
        end else begin
            int v;
            v = m_lru[s];
            rq = "R2";
            if (m_st[v][s] == 2'd3) begin
                rq = "R10"; ewb = 4; ewba = {m_tag[v][s], s, 5'b0};
            end
            ef = 4;
            m_st[v][s]  = mode ? 2'd2 : 2'd1;
            m_tag[v][s] = t;
            m_lru[s]    = (v == 0);
        end
        @(negedge clk);
        clear_log();
        cpu_we = we; cpu_addr = a; wb_mode = mode; cache_dis = dis; cpu_req = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!cpu_done && k < 200);
        a_hit = cpu_hit;
        cpu_req = 1'b0;
        chk(cpu_done == 1'b1, rq, "cpu completion", {63'b0, cpu_done}, 64'd1);
        es  = {e_hit, ef[3:0], ewb[3:0], ewt[3:0], erd[3:0]};
        as_ = {a_hit, n_fill[3:0], n_wb[3:0], n_wt[3:0], n_rd[3:0]};
        chk(as_ == es, rq, "hit/fill/wb/wt/rd beats", {47'b0, as_}, {47'b0, es});
        if (ewb != 0) chk(a_wb == ewba, "R10", "victim address", {32'b0, a_wb}, {32'b0, ewba});
        if (ef != 0)  chk(a_fill == line_of(a), "R12", "refill address", {32'b0, a_fill}, {32'b0, line_of(a)});
        if (ewt != 0) chk(a_wt == a, "R12", "write-through address", {32'b0, a_wt}, {32'b0, a});
        if (erd != 0) chk(a_rd == a, "R11", "uncached address", {32'b0, a_rd}, {32'b0, a});
    endtask

    task automatic snp_op(input bit we, input logic [31:0] a);
        logic [19:0] t;
        logic [6:0]  s;
        int          hw, ewb, k;
        bit          e_hit, e_hm;
        logic [9:0]  es, as_;
        string       rq;
        t = a[31:12]; s = a[11:5];
        hw = -1; ewb = 0; e_hit = 0; e_hm = 0;
        for (int w = 0; w < 2; w++)
            if (m_st[w][s] != 2'd0 && m_tag[w][s] == t) hw = w;
        rq = we ? "R8" : "R9";
        if (hw >= 0) begin
            e_hit = 1;
            if (m_st[hw][s] == 2'd3) begin
                e_hm = 1; ewb = 4;
                if (!we) rq = "R7";
            end
            m_st[hw][s] = we ? 2'd0 : 2'd1;
        end
        @(negedge clk);
        clear_log();
        snp_we = we; snp_addr = a; snp_req = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!snp_done && k < 200);
        es  = {e_hit, e_hm, ewb[3:0], 4'(n_wt + n_fill + n_rd) & 4'd0};
        as_ = {snp_hit, snp_hitm, n_wb[3:0], 4'(n_wt + n_fill + n_rd)};
        snp_req = 1'b0;
        chk(snp_done == 1'b1, rq, "snoop completion", {63'b0, snp_done}, 64'd1);
        chk(as_ == es, rq, "hit/hitm/wb beats/other beats", {54'b0, as_}, {54'b0, es});
        if (ewb != 0) chk(a_wb == line_of(a), rq, "snoop write-back address",
                          {32'b0, a_wb}, {32'b0, line_of(a)});
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 128; s++) begin m_st[w][s] = 2'd0; m_tag[w][s] = '0; end
        for (int s = 0; s < 128; s++) m_lru[s] = 1'b0;
        clear_log();
        repeat (3) @(negedge clk);
        // R1: quiet outputs in and right after reset
        chk({fill_req, wb_req, wt_req, rd_req, cpu_done, snp_done} == 6'b0, "R1",
            "outputs in reset", {58'b0, fill_req, wb_req, wt_req, rd_req, cpu_done, snp_done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({fill_req, wb_req, wt_req, rd_req, cpu_done, snp_done} == 6'b0, "R1",
            "outputs after reset", {58'b0, fill_req, wb_req, wt_req, rd_req, cpu_done, snp_done}, 64'd0);
        // R1, R2 first read misses; R3 hit; R4 write E -> M; R7 read snoop of M
        cpu_op(0, mk(1, 5, 8), 1, 0);
        cpu_op(0, mk(1, 5, 16), 1, 0);
        cpu_op(1, mk(1, 5, 16), 1, 0);
        snp_op(0, mk(1, 5, 0));
        // R5 write to Shared goes out; R8 write snoop invalidates
        cpu_op(1, mk(1, 5, 24), 1, 0);
        snp_op(1, mk(1, 5, 0));
        cpu_op(0, mk(1, 5, 0), 0, 0);      // misses again, refill in write-through mode
        snp_op(0, mk(1, 5, 0));            // R9 hit on Shared
        cpu_op(1, mk(1, 5, 8), 0, 0);      // R5 write-through mode line stays Shared
        snp_op(0, mk(7, 5, 0));            // R9 snoop miss
        // R6 write miss does not allocate
        cpu_op(1, mk(2, 6, 8), 1, 0);
        cpu_op(0, mk(2, 6, 8), 1, 0);
        // R10 replacement and dirty victim
        cpu_op(0, mk(1, 9, 0), 1, 0);
        cpu_op(0, mk(2, 9, 0), 1, 0);
        cpu_op(1, mk(1, 9, 0), 1, 0);
        cpu_op(0, mk(3, 9, 0), 1, 0);
        cpu_op(1, mk(3, 9, 0), 1, 0);
        cpu_op(0, mk(1, 9, 0), 1, 0);
        cpu_op(0, mk(4, 9, 0), 1, 0);
        snp_op(1, mk(1, 9, 0));            // R8 write snoop on Modified
        // R11 cache disabled
        cpu_op(0, mk(1, 5, 8), 1, 1);
        cpu_op(1, mk(1, 5, 8), 1, 1);
        cpu_op(0, mk(1, 5, 8), 1, 0);
        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            int kind;
            logic [31:0] a;
            kind = $urandom % 10;
            a = mk($urandom % 4, $urandom % 4, ($urandom % 4) * 8);
            if (kind < 6) cpu_op($urandom % 2, a, $urandom % 2, ($urandom % 10) == 0);
            else snp_op($urandom % 2, a);
        end
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule